// File: doc/BRIEF.md
# 100BASE-X PCS Receive Aligner and Decoder

This block sits between clock recovery and the MII receive pins of a 100 Mb/s physical layer. It takes one recovered line bit per clock. It removes the transmit scrambling with a self-synchronising 11-bit descrambler. It then hunts the plain bit stream for the start-of-stream delimiter pair, and that pair fixes the 5-bit code-group boundary. From then on it turns each code group into a receive nibble. It raises data-valid for the span of the packet and flags bad groups. It drops the end-of-stream delimiter and returns to hunting once the packet ends.

Carrier sense follows the line. It rises on the first zero bit seen while hunting. It falls once ten consecutive one bits are seen, or when the packet ends. A symbol-mode input replaces the decoded nibble with the raw 5-bit group, split across the nibble bus and the error line.

Top module: `pcs_rx_aligner`

## Requirements
- R1: With descrambling enabled, `lock` is 0 after reset and stays 0 for at least the first LOCK_RUN bits. It rises once LOCK_RUN consecutive descrambled bits are 1 (idle), and then stays high until reset. While descrambling is enabled and `lock` is 0, `crs` and `rxDv` stay 0.
- R2: With `scramEn` low, line bits are used unaltered, and the hunt for the delimiter runs whatever the value of `lock`.
- R3: The delimiter is the 10-bit plain sequence 1,1,0,0,0,1,0,0,0,1 (first received bit first), i.e. J=11000 followed by K=10001. On the clock that takes in its last bit, `rxDv` rises with `rxd`=0x5 and `rxEr`=0, whatever the bit offset of the delimiter relative to earlier traffic.
- R4: The K group is presented as a second 0x5 nibble, 5 clocks after `rxDv` rises.
- R5: Each later group is decoded to a nibble using this table: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101 (first received bit is the leftmost). The nibble appears on the clock that takes in the last bit of the following group. It is held for 5 clocks.
- R6: A T group (01101) followed by an R group (00111) ends the packet. On the clock of the last R bit, `rxDv`, `crs`, `rxd` and `rxEr` go to 0, and T is never presented.
- R7: A group within the packet that is neither in the R5 table nor in the J/K preamble position (for example 00000, or a J) gives `rxEr`=1 and `rxd`=0 for its nibble period, with `rxDv` staying 1. `rxEr` is never 1 while `rxDv` is 0.
- R8: An IDLE group (11111) within a packet ends it, in the same way and at the same point in the group sequence as a T group does under R6.
- R9: While hunting, a plain 0 bit raises `crs` on the clock that takes it in. `crs` falls on the clock that completes ten consecutive plain 1 bits, and `rxDv` stays 0 when no delimiter is found.
- R10: With `symMode` high, each presented group (J and K included) appears raw: `rxEr` carries its first received bit and `rxd` its last four bits, with the same framing and timing as R3 to R6.
- R11: During reset `rxd`, `rxDv`, `rxEr`, `crs` and `lock` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock, one line bit per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Recovered line bit |
| scramEn | input | 1 | 1 = descramble the line bits, 0 = use them as received |
| symMode | input | 1 | 1 = present raw 5-bit groups instead of decoded nibbles |
| rxd | output | 4 | Receive nibble |
| rxDv | output | 1 | Receive data valid |
| rxEr | output | 1 | Receive error (raw first bit in symbol mode) |
| crs | output | 1 | Carrier sense |
| lock | output | 1 | Descrambler synchronised |

## Verification
All outputs are registered once after the bit that decides them. Carrier changes on the clock of the deciding bit, and the delimiter match raises data-valid on the clock of the tenth delimiter bit. Each group's nibble is due exactly five clocks after its own last bit, because it is shown while the next group arrives. The bench therefore drives bits one per clock and samples a quarter-period past the edge that took in the last bit of each group. It compares the sample against the nibble of the group one place earlier in its own sequence. Packets are swept over all 16 nibble values and all five bit offsets, with scrambling both on and off, and the bench's scrambler runs on every clock so that it stays in step with the design.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;

  localparam logic [9:0] DELIM_START = 10'b11000_10001;
  localparam logic [9:0] DELIM_END   = 10'b01101_00111;
  localparam logic [4:0] GROUP_IDLE  = 5'b11111;

  typedef struct packed {
    logic load;   // capture the group presented in the upper window half
    logic pre;    // group is a start delimiter: present 0x5
    logic clear;  // zero the nibble and error outputs
  } rxStrobe_t;

  typedef struct packed {
    logic       valid;
    logic [3:0] nib;
  } decoded_t;

  function automatic decoded_t decodeGroup(input logic [4:0] g);
    decoded_t d;
    d.valid = 1'b1;
    unique case (g)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      default: begin
        d.valid = 1'b0;
        d.nib   = 4'h0;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pcs_rx_dp.sv
module pcs_rx_dp
  import pcs_rx_pkg::*;
#(
  parameter int LOCK_RUN = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  logic       scramEn,
  input  logic       symMode,
  input  rxStrobe_t  strb,
  output logic [9:0] winNow,
  output logic       lock,
  output logic [3:0] rxd,
  output logic       rxEr
);

  localparam int LFSR_W = 11;
  localparam int CNT_W  = $clog2(LOCK_RUN + 1);

  logic [LFSR_W-1:0] lfsr;
  logic [8:0]        win;
  logic [CNT_W-1:0]  runCnt;
  logic              keyPred, plainBit, lfsrIn;
  decoded_t          dec;

  // Descrambler: predicted key from x^11 + x^9 + 1; before lock the
  // register is seeded from inverted line bits (idle is all ones).
  assign keyPred  = lfsr[10] ^ lfsr[8];
  assign plainBit = scramEn ? (rxBit ^ keyPred) : rxBit;
  assign lfsrIn   = lock ? keyPred : ~rxBit;
  assign winNow   = {win, plainBit};
  assign dec      = decodeGroup(winNow[9:5]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr   <= '0;
      win    <= '0;
      runCnt <= '0;
      lock   <= 1'b0;
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], lfsrIn};
      win  <= winNow[8:0];
      if (!lock) begin
        if (scramEn && plainBit) begin
          if (runCnt == CNT_W'(LOCK_RUN - 1)) lock <= 1'b1;
          else runCnt <= runCnt + 1'b1;
        end else begin
          runCnt <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      rxd  <= '0;
      rxEr <= 1'b0;
    end else if (strb.load) begin
      if (symMode) begin
        {rxEr, rxd} <= winNow[9:5];
      end else if (strb.pre) begin
        rxd  <= 4'h5;
        rxEr <= 1'b0;
      end else begin
        rxd  <= dec.nib;
        rxEr <= ~dec.valid;
      end
    end
  end

  a_r1_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lock |=> lock);

  a_r1_no_early_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lock) |-> $past(scramEn));

endmodule

// File: rtl/pcs_rx_ctl.sv
module pcs_rx_ctl
  import pcs_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       scramEn,
  input  logic       lock,
  input  logic [9:0] winNow,
  output rxStrobe_t  strb,
  output logic       rxDv,
  output logic       crs
);

  typedef enum logic { HUNT, FRAME } ctlState_t;

  ctlState_t  state;
  logic [2:0] bitCnt;
  logic       kNext;
  logic       huntOk, startHit, boundary, packetEnd;

  assign huntOk    = lock | ~scramEn;
  assign startHit  = (state == HUNT) && huntOk && (winNow == DELIM_START);
  assign boundary  = (state == FRAME) && (bitCnt == 3'd4);
  assign packetEnd = boundary &&
                     ((winNow == DELIM_END) || (winNow[9:5] == GROUP_IDLE));

  always_comb begin
    strb       = '0;
    strb.load  = startHit || (boundary && !packetEnd);
    strb.pre   = startHit || (boundary && kNext);
    strb.clear = packetEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= HUNT;
      bitCnt <= '0;
      kNext  <= 1'b0;
      rxDv   <= 1'b0;
      crs    <= 1'b0;
    end else if (state == HUNT) begin
      if (startHit) begin
        state  <= FRAME;
        bitCnt <= '0;
        kNext  <= 1'b1;
        rxDv   <= 1'b1;
        crs    <= 1'b1;
      end else if (!huntOk) begin
        crs <= 1'b0;
      end else if (!winNow[0]) begin
        crs <= 1'b1;
      end else if (&winNow) begin
        crs <= 1'b0;
      end
    end else begin
      bitCnt <= boundary ? 3'd0 : bitCnt + 3'd1;
      if (packetEnd) begin
        state <= HUNT;
        rxDv  <= 1'b0;
        crs   <= 1'b0;
        kNext <= 1'b0;
      end else if (boundary) begin
        kNext <= 1'b0;
      end
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 3'd4);

  a_r9_dv_under_crs: assert property (@(posedge clk) disable iff (!rstN)
    rxDv |-> crs);

  a_r6_end_drops_dv: assert property (@(posedge clk) disable iff (!rstN)
    packetEnd |=> !rxDv && !crs);

endmodule

// File: rtl/pcs_rx_aligner.sv
module pcs_rx_aligner
  import pcs_rx_pkg::*;
#(
  parameter int LOCK_RUN = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  logic       scramEn,
  input  logic       symMode,
  output logic [3:0] rxd,
  output logic       rxDv,
  output logic       rxEr,
  output logic       crs,
  output logic       lock
);

  rxStrobe_t  strb;
  logic [9:0] winNow;

  pcs_rx_dp #(.LOCK_RUN(LOCK_RUN)) u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .scramEn(scramEn),
    .symMode(symMode), .strb(strb), .winNow(winNow), .lock(lock),
    .rxd(rxd), .rxEr(rxEr)
  );

  pcs_rx_ctl u_ctl (
    .clk(clk), .rstN(rstN), .scramEn(scramEn), .lock(lock),
    .winNow(winNow), .strb(strb), .rxDv(rxDv), .crs(crs)
  );

  a_r7_err_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    rxEr |-> rxDv);

  a_r3_first_nibble: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxDv) && !$past(symMode)) |-> (rxd == 4'h5 && !rxEr));

endmodule

// File: tb/sim_pcs_rx_aligner.sv
module sim_pcs_rx_aligner;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxBit = 1'b1;
  logic       scramEn = 1'b1;
  logic       symMode = 1'b0;
  logic [3:0] rxd;
  logic       rxDv, rxEr, crs, lock;

  int checks = 0;
  int errors = 0;
  logic [10:0] txLfsr = 11'h5A3;

  localparam logic [4:0] G_J = 5'b11000, G_K = 5'b10001, G_T = 5'b01101,
                         G_R = 5'b00111, G_I = 5'b11111;

  always #2 clk = ~clk;

  pcs_rx_aligner u0 (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .scramEn(scramEn),
    .symMode(symMode), .rxd(rxd), .rxDv(rxDv), .rxEr(rxEr),
    .crs(crs), .lock(lock)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one plain bit per clock; the bench scrambler advances every clock
  task automatic sendBit(input logic b);
    logic key;
    @(negedge clk);
    key = txLfsr[10] ^ txLfsr[8];
    txLfsr = {txLfsr[9:0], key};
    rxBit = scramEn ? (b ^ key) : b;
    @(posedge clk);
    #1;
  endtask

  task automatic sendGroup(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) sendBit(g[i]);
  endtask

  task automatic outState(input string req, input logic dv, input logic [3:0] n,
                          input logic er);
    chk({req, " rxDv"}, rxDv, dv);
    chk({req, " rxd"}, rxd, n);
    chk({req, " rxEr"}, rxEr, er);
  endtask

  // full packet of 16 nibbles starting at value first, delimiter shifted by off bits
  task automatic runPacket(input int off, input logic [3:0] first);
    for (int i = 0; i < off; i++) sendBit(1'b1);
    sendGroup(G_J);
    chk("R9 crs on J", crs, 1);
    chk("R3 no dv before K", rxDv, 0);
    sendGroup(G_K);
    outState("R3 start", 1'b1, 4'h5, 1'b0);
    sendGroup(enc(first));
    outState("R4 K nibble", 1'b1, 4'h5, 1'b0);
    for (int i = 0; i < 16; i++) begin
      sendGroup(i == 15 ? G_T : enc(4'(first + 4'(i + 1))));
      outState("R5 data", 1'b1, 4'(first + 4'(i)), 1'b0);
    end
    sendGroup(G_R);
    outState("R6 end", 1'b0, 4'h0, 1'b0);
    chk("R6 crs end", crs, 0);
    sendGroup(G_I);
    sendGroup(G_I);
    chk("R6 idle after", crs, 0);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    outState("R11 reset", 1'b0, 4'h0, 1'b0);
    chk("R11 crs", crs, 0);
    chk("R11 lock", lock, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 29; i++) sendBit(1'b1);
    chk("R1 no early lock", lock, 0);
    chk("R1 no crs unlocked", crs, 0);
    for (int i = 0; i < 31; i++) sendBit(1'b1);
    chk("R1 locked", lock, 1);
    for (int i = 0; i < 4; i++) sendGroup(G_I);
    chk("R1 idle crs", crs, 0);
    chk("R1 idle dv", rxDv, 0);

    for (int k = 0; k < 10; k++) begin
      scramEn = (k % 2 == 0);
      runPacket(k % 5, 4'(k * 3));
      chk("R2 lock held", lock, 1);
    end
    scramEn = 1'b1;

    // R7 invalid groups
    sendGroup(G_J); sendGroup(G_K);
    sendGroup(enc(4'h3));
    sendGroup(5'b00000);
    outState("R7 before bad", 1'b1, 4'h3, 1'b0);
    sendGroup(enc(4'h7));
    outState("R7 zero group", 1'b1, 4'h0, 1'b1);
    sendGroup(G_J);
    outState("R7 after bad", 1'b1, 4'h7, 1'b0);
    sendGroup(G_T);
    outState("R7 J in data", 1'b1, 4'h0, 1'b1);
    sendGroup(G_R);
    outState("R7 end", 1'b0, 4'h0, 1'b0);
    sendGroup(G_I); sendGroup(G_I);

    // R8 idle inside a packet
    sendGroup(G_J); sendGroup(G_K);
    sendGroup(enc(4'h9));
    outState("R8 K", 1'b1, 4'h5, 1'b0);
    sendGroup(G_I);
    outState("R8 last data", 1'b1, 4'h9, 1'b0);
    sendGroup(G_I);
    outState("R8 idle end", 1'b0, 4'h0, 1'b0);
    chk("R8 crs", crs, 0);
    sendGroup(G_I);

    // R9 false carrier
    sendGroup(5'b10101);
    chk("R9 crs rise", crs, 1);
    chk("R9 no dv", rxDv, 0);
    sendGroup(G_I);
    chk("R9 crs held", crs, 1);
    sendGroup(G_I);
    chk("R9 crs fall", crs, 0);
    chk("R9 dv low", rxDv, 0);

    // R10 symbol mode
    symMode = 1'b1;
    sendGroup(G_J); sendGroup(G_K);
    outState("R10 J raw", 1'b1, 4'h8, 1'b1);
    sendGroup(enc(4'hA));
    outState("R10 K raw", 1'b1, 4'h1, 1'b1);
    sendGroup(enc(4'h3));
    outState("R10 A raw", 1'b1, 4'h6, 1'b1);
    sendGroup(G_T);
    outState("R10 3 raw", 1'b1, 4'h5, 1'b1);
    sendGroup(G_R);
    outState("R10 end", 1'b0, 4'h0, 1'b0);
    symMode = 1'b0;
    sendGroup(G_I); sendGroup(G_I);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule